// File: doc/BRIEF.md
# Per-Core Interval Tick Timer

This block is a local timer channel built from two counters in series. A tick prescaler divides the input clock by a programmable amount. An interrupt counter then counts those ticks down from a programmed interval. When the interval runs out, the block sets a pending flag, and that flag drives the interrupt line when it is enabled. In interval mode the interrupt counter reloads itself from its buffer, so interrupts keep arriving until software stops the timer. Otherwise the counter parks at zero after a single interrupt.

Software reaches the block through a plain 32-bit register port. A write happens in the cycle `reg_wr` is high. Reads are combinational from `reg_addr`. The block carries no streaming data, so it has no valid/ready pair and no back-pressure: every write is taken in the cycle it is presented.

Each write to the tick buffer, the interrupt buffer or the control register raises its own acknowledge flag in a write-status register. Software clears a flag by writing 1 to it.

Top module: `tick_timer`

## Requirements
- R1: After reset every register reads 0 and `irq` is low.
- R2: A write to the tick buffer (offset 0x00) stores the value T and also loads it into the tick counter. While control bit 0 (offset 0x20) is 1, the tick counter counts down and emits one tick every T+1 clocks, reloading T when it reaches 0. The live tick count reads at 0x04.
- R3: While control bit 1 is also 1, each tick decrements the interrupt counter. The tick that takes it from 1 to 0 sets pending, which is bit 0 of offset 0x30. With the control write at edge E0, the first interrupt is raised at edge E0+N*(T+1).
- R4: With control bit 2 (interval mode) set, expiry reloads the interrupt counter from its buffer, so interrupts recur every N*(T+1) clocks.
- R5: The write-status register (0x40) sets bit 0 on a write to 0x00, bit 1 on a write to 0x08 and bit 3 on a write to 0x20. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R6: `irq` is pending AND bit 0 of the enable register (0x34). Writing 1 to bit 0 of 0x30 clears pending, and writing 0 there has no effect.
- R7: With control bit 2 clear, expiry leaves the interrupt counter at 0 and no further interrupt occurs.
- R8: A write to 0x08 always stores bits 30:0 in the interrupt buffer. It loads the running interrupt counter only when bit 31 is 1. The live interrupt count reads at 0x0C.
- R9: Clearing a start bit stops the counter it controls and holds that counter's value.
- R10: T=0 gives a tick every clock and T=1 gives a tick every two clocks.
- R11: When an expiry and a pending-clear write fall in the same cycle, pending stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 7 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
Two functions can fall in the same clock edge: the interrupt counter expiring, and a software write that clears the pending flag. The bench provokes this with a tick every clock (T=0) and an interval of 5. It waits for the first interrupt, then places the clear write so that it lands exactly on the edge of the second expiry. The expected result is that `irq` stays high across that edge, because the new expiry must win over the clear. A later clear, on an edge with no expiry, must then drop `irq`.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  localparam int unsigned REG_AW = 7;

  localparam logic [REG_AW-1:0] OFS_TICK_BUF = 7'h00;
  localparam logic [REG_AW-1:0] OFS_TICK_NOW = 7'h04;
  localparam logic [REG_AW-1:0] OFS_INT_BUF  = 7'h08;
  localparam logic [REG_AW-1:0] OFS_INT_NOW  = 7'h0C;
  localparam logic [REG_AW-1:0] OFS_CTRL     = 7'h20;
  localparam logic [REG_AW-1:0] OFS_PEND     = 7'h30;
  localparam logic [REG_AW-1:0] OFS_IRQEN    = 7'h34;
  localparam logic [REG_AW-1:0] OFS_WACK     = 7'h40;

  localparam int unsigned WACK_W = 4;
  localparam logic [WACK_W-1:0] WACK_MASK = 4'b1011;

  typedef struct packed {
    logic interval;
    logic int_run;
    logic tick_run;
  } ctrl_t;
endpackage

// File: rtl/tt_prescaler.sv
module tt_prescaler #(
  parameter int TICK_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              load,
  input  logic [TICK_W-1:0] load_val,
  input  logic [TICK_W-1:0] period,
  output logic              tick,
  output logic [TICK_W-1:0] count
);
  assign tick = run && (count == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       count <= '0;
    else if (load)    count <= load_val;
    else if (tick)    count <= period;
    else if (run)     count <= count - 1'b1;
  end
endmodule

// File: rtl/tt_interval.sv
module tt_interval #(
  parameter int INT_W = 31
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             enable,
  input  logic             interval,
  input  logic             load,
  input  logic [INT_W-1:0] load_val,
  input  logic [INT_W-1:0] reload_val,
  output logic             expire,
  output logic [INT_W-1:0] count
);
  localparam logic [INT_W-1:0] ONE = INT_W'(1);

  logic active;
  assign active = tick && enable && (count != '0);
  assign expire = active && (count == ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       count <= '0;
    else if (load)    count <= load_val;
    else if (expire)  count <= interval ? reload_val : '0;
    else if (active)  count <= count - 1'b1;
  end
endmodule

// File: rtl/tt_regs.sv
module tt_regs
  import tick_timer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int INT_W  = DATA_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic [DATA_W-1:0] tick_cnt,
  input  logic [INT_W-1:0]  int_cnt,
  input  logic              expire,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [DATA_W-1:0] tick_buf,
  output logic [INT_W-1:0]  int_buf,
  output ctrl_t             ctrl,
  output logic              pend,
  output logic              irq_en,
  output logic [WACK_W-1:0] wack,
  output logic              tick_load,
  output logic              int_load
);
  logic wr_tick, wr_int, wr_ctrl, wr_pend, wr_en, wr_wack;
  logic [WACK_W-1:0] wack_set, wack_clr;

  assign wr_tick = reg_wr && (reg_addr == OFS_TICK_BUF);
  assign wr_int  = reg_wr && (reg_addr == OFS_INT_BUF);
  assign wr_ctrl = reg_wr && (reg_addr == OFS_CTRL);
  assign wr_pend = reg_wr && (reg_addr == OFS_PEND);
  assign wr_en   = reg_wr && (reg_addr == OFS_IRQEN);
  assign wr_wack = reg_wr && (reg_addr == OFS_WACK);

  assign tick_load = wr_tick;
  assign int_load  = wr_int && reg_wdata[DATA_W-1];

  assign wack_set = {wr_ctrl, 1'b0, wr_int, wr_tick};
  assign wack_clr = wr_wack ? (reg_wdata[WACK_W-1:0] & WACK_MASK) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_buf <= '0;
      int_buf  <= '0;
      ctrl     <= '0;
      pend     <= 1'b0;
      irq_en   <= 1'b0;
      wack     <= '0;
    end else begin
      if (wr_tick) tick_buf <= reg_wdata;
      if (wr_int)  int_buf  <= reg_wdata[INT_W-1:0];
      if (wr_ctrl) ctrl     <= ctrl_t'(reg_wdata[2:0]);
      if (wr_en)   irq_en   <= reg_wdata[0];
      if (expire)                     pend <= 1'b1;
      else if (wr_pend && reg_wdata[0]) pend <= 1'b0;
      wack <= (wack & ~wack_clr) | wack_set;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      OFS_TICK_BUF: reg_rdata = tick_buf;
      OFS_TICK_NOW: reg_rdata = tick_cnt;
      OFS_INT_BUF:  reg_rdata = DATA_W'(int_buf);
      OFS_INT_NOW:  reg_rdata = DATA_W'(int_cnt);
      OFS_CTRL:     reg_rdata = DATA_W'(ctrl);
      OFS_PEND:     reg_rdata = DATA_W'(pend);
      OFS_IRQEN:    reg_rdata = DATA_W'(irq_en);
      OFS_WACK:     reg_rdata = DATA_W'(wack);
      default:      reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  localparam int INT_W = DATA_W - 1;

  logic [DATA_W-1:0] tick_buf, tick_cnt;
  logic [INT_W-1:0]  int_buf, int_cnt;
  ctrl_t             ctrl;
  logic              pend, irq_en, tick, expire, tick_load, int_load;
  logic [WACK_W-1:0] wack;

  tt_regs #(.DATA_W(DATA_W), .INT_W(INT_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .tick_cnt(tick_cnt), .int_cnt(int_cnt),
    .expire(expire), .reg_rdata(reg_rdata), .tick_buf(tick_buf),
    .int_buf(int_buf), .ctrl(ctrl), .pend(pend), .irq_en(irq_en),
    .wack(wack), .tick_load(tick_load), .int_load(int_load)
  );

  tt_prescaler #(.TICK_W(DATA_W)) pre_i (
    .clk(clk), .rst_n(rst_n), .run(ctrl.tick_run), .load(tick_load),
    .load_val(reg_wdata), .period(tick_buf), .tick(tick), .count(tick_cnt)
  );

  tt_interval #(.INT_W(INT_W)) ivl_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .enable(ctrl.int_run),
    .interval(ctrl.interval), .load(int_load),
    .load_val(reg_wdata[INT_W-1:0]), .reload_val(int_buf),
    .expire(expire), .count(int_cnt)
  );

  assign irq = pend & irq_en;
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk
  import tick_timer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int INT_W  = DATA_W - 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [REG_AW-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              tick,
  input logic              expire,
  input logic              interval,
  input logic              tick_run,
  input logic [DATA_W-1:0] tick_cnt,
  input logic [INT_W-1:0]  int_cnt,
  input logic [INT_W-1:0]  int_buf,
  input logic              pend,
  input logic [WACK_W-1:0] wack
);
  logic wr_int;
  assign wr_int = reg_wr && (reg_addr == OFS_INT_BUF);

  p_pend_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> pend);

  p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && interval && !wr_int) |=> (int_cnt == $past(int_buf)));

  p_wack_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == OFS_TICK_BUF) |=> wack[0]);

  p_wack_ctrl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == OFS_CTRL) |=> wack[3]);

  p_oneshot_park_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !interval && !wr_int) |=> (int_cnt == '0));

  p_no_update_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_int && !reg_wdata[DATA_W-1] && !tick) |=> $stable(int_cnt));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_run && !(reg_wr && reg_addr == OFS_TICK_BUF)) |=> $stable(tick_cnt));

  p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && reg_wr && reg_addr == OFS_PEND && reg_wdata[0]) |=> pend);
endmodule

bind tick_timer tick_timer_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .tick(tick), .expire(expire),
  .interval(ctrl.interval), .tick_run(ctrl.tick_run), .tick_cnt(tick_cnt),
  .int_cnt(int_cnt), .int_buf(int_buf), .pend(pend), .wack(wack)
);

// File: tb/tick_timer_tb_top.sv
module tick_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [6:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  int cyc = 0;
  int errors = 0;
  int checks = 0;
  int exp_q[$];
  logic irq_q = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  tick_timer dut_i (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
                    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq));

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d, output int edge_n);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    edge_n = cyc;
  endtask

  task automatic wr0(input logic [6:0] a, input logic [31:0] d);
    int e;
    wr(a, d, e);
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic expect_rd(input logic [6:0] a, input logic [31:0] e, input string req);
    logic [31:0] v;
    rd(a, v);
    check(v == e, req, v, e);
  endtask

  task automatic setup(input int t, input int n, input logic [31:0] c, output int e0);
    wr0(7'h20, 32'h0);
    wr0(7'h30, 32'h1);
    wr0(7'h00, t);
    wr0(7'h08, 32'h8000_0000 | n);
    wr(7'h20, c, e0);
  endtask

  task automatic wait_irq();
    do @(negedge clk); while (!irq);
  endtask

  // monitor: compares each irq rise with the next expected cycle
  initial forever begin
    @(negedge clk);
    if (irq && !irq_q) begin
      if (exp_q.size() == 0) check(1'b0, "R3 unexpected irq", cyc, 0);
      else begin
        int e;
        e = exp_q.pop_front();
        check(cyc == e, "R3 irq rise cycle", cyc, e);
      end
    end
    irq_q = irq;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int e0;
    logic [31:0] a, b;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    expect_rd(7'h00, 0, "R1 tick buf");
    expect_rd(7'h08, 0, "R1 int buf");
    expect_rd(7'h20, 0, "R1 ctrl");
    expect_rd(7'h30, 0, "R1 pend");
    expect_rd(7'h34, 0, "R1 enable");
    expect_rd(7'h40, 0, "R1 wack");
    check(irq == 1'b0, "R1 irq", irq, 0);

    // R5 write acknowledge flags
    wr0(7'h00, 32'd7);
    wr0(7'h08, 32'h8000_0003);
    wr0(7'h20, 32'h0);
    expect_rd(7'h40, 32'hB, "R5 wack set");
    wr0(7'h40, 32'h1);
    expect_rd(7'h40, 32'hA, "R5 wack clear bit0");
    wr0(7'h40, 32'h0);
    expect_rd(7'h40, 32'hA, "R5 wack write 0");
    wr0(7'h40, 32'hA);
    expect_rd(7'h40, 32'h0, "R5 wack cleared");

    // R2 R3 R4 interval mode, T=3 N=4
    wr0(7'h34, 32'h1);
    setup(3, 4, 32'h7, e0);
    exp_q.push_back(e0 + 16); exp_q.push_back(e0 + 32); exp_q.push_back(e0 + 48);
    for (int i = 0; i < 3; i++) begin
      wait_irq();
      wr0(7'h30, 32'h1);
    end
    wr0(7'h20, 32'h0);
    wr0(7'h30, 32'h1);
    check(exp_q.size() == 0, "R4 all interval irqs", exp_q.size(), 0);

    // R10 T=1 gives tick every two clocks
    setup(1, 2, 32'h7, e0);
    exp_q.push_back(e0 + 4); exp_q.push_back(e0 + 8);
    wait_irq(); wr0(7'h30, 32'h1);
    wait_irq(); wr0(7'h20, 32'h0); wr0(7'h30, 32'h1);
    check(exp_q.size() == 0, "R10 T=1 irqs", exp_q.size(), 0);

    // R7 one-shot parks
    setup(1, 3, 32'h3, e0);
    exp_q.push_back(e0 + 6);
    wait_irq(); wr0(7'h30, 32'h1);
    repeat (30) @(negedge clk);
    expect_rd(7'h0C, 0, "R7 count parked");
    check(irq == 1'b0, "R7 no further irq", irq, 0);

    // R6 enable gating and pending clear
    wr0(7'h34, 32'h0);
    setup(0, 2, 32'h3, e0);
    repeat (10) @(negedge clk);
    check(irq == 1'b0, "R6 gated irq", irq, 0);
    expect_rd(7'h30, 1, "R6 pending set");
    wr0(7'h30, 32'h0);
    expect_rd(7'h30, 1, "R6 write 0 no clear");
    wr0(7'h30, 32'h1);
    expect_rd(7'h30, 0, "R6 write 1 clears");
    wr0(7'h34, 32'h1);

    // R9 hold on stop, R8 update flag
    setup(5, 100, 32'h7, e0);
    repeat (20) @(negedge clk);
    wr0(7'h20, 32'h6);
    expect_rd(7'h04, 1, "R2 R9 tick count held");
    expect_rd(7'h0C, 97, "R9 int count held");
    repeat (10) @(negedge clk);
    rd(7'h04, a); rd(7'h0C, b);
    check(a == 1, "R9 tick stable", a, 1);
    check(b == 97, "R9 int stable", b, 97);
    wr0(7'h08, 32'h9);
    expect_rd(7'h08, 9, "R8 buffer stored");
    expect_rd(7'h0C, 97, "R8 counter not loaded");
    wr0(7'h08, 32'h8000_0007);
    expect_rd(7'h0C, 7, "R8 update loads");
    wr0(7'h20, 32'h0);

    // R11 expiry and clear in the same cycle, T=0 N=5
    setup(0, 5, 32'h7, e0);
    exp_q.push_back(e0 + 5);
    while (cyc != e0 + 8) @(negedge clk);
    wr0(7'h30, 32'h1);
    check(irq == 1'b1, "R11 set wins over clear", irq, 1);
    wr0(7'h20, 32'h0);
    wr0(7'h30, 32'h1);
    check(irq == 1'b0, "R6 R11 later clear", irq, 0);

    repeat (5) @(negedge clk);
    check(exp_q.size() == 0, "R3 expected irqs seen", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule